// File: doc/BRIEF.md
# I2C Status Flag Sequencer

This block keeps the four low event flags of an I2C controller's first status register. The flags are start generated, address sent or matched, byte transfer finished and 10-bit header sent. The bus engine reports what happened on the wire as one-cycle event pulses. The block turns those pulses into sticky flags. It applies the suppression rules for NACK, disabled clock stretching and the error-check byte.

Software acknowledges a flag with two register accesses. The first is always a read of status register 1, made while the flag is high. The second depends on the flag: a data-register write, a status-2 read, or either data-register access. A second access that comes without a qualifying status-1 read leaves the flag alone. Clearing the peripheral enable wipes every flag at once. The controller places `statusLo` directly into the low bits of its status register.

Top module: `i2c_status_flags`

## Requirements
- R1: A synchronous reset drives all four flags to 0. The bit positions in `statusLo` are: bit 0 start, bit 1 address, bit 2 byte finished, bit 3 10-bit header. Each flag appears one clock after the event that sets or clears it.
- R2: The start flag sets on `evStartGen`. It clears on a `wrData` that follows a qualifying `rdStat1`.
- R3: The header flag sets on `evMAddr` when `tenBitMode`=1, `mAddrSecond`=0 and `nackIn`=0. It never sets when the byte was NACKed. It clears on a `wrData` that follows a qualifying `rdStat1`.
- R4: The master address flag sets on an `evMAddr` that was ACKed (`nackIn`=0). In 7-bit mode (`tenBitMode`=0) any such byte sets it. In 10-bit mode only the second byte (`mAddrSecond`=1) sets it.
- R5: The slave address flag sets on `evSlvMatch` according to `matchKind`. Kind 0 is the own address and always counts. Kinds 1, 2, 3 and 4 are general call, SMBus device default, SMBus host and SMBus alert. Each of kinds 1 to 4 counts only when `matchEn[kind-1]`=1. Kinds 5 to 7 never count.
- R6: The address flag clears on an `rdStat2` that follows a qualifying `rdStat1`.
- R7: The byte-finished flag sets on `evByteDone` only when all of these hold: `stretchOff`=0, `nackIn`=0, and one of the following. In receive (`txDir`=0), `rxNotEmpty`=1. In transmit (`txDir`=1), `txEmpty`=1 and `errChkOn`=0.
- R8: The byte-finished flag clears on `rdData` or `wrData` after a qualifying `rdStat1`. In transmit it also clears on `evStartGen` or `evStopSeen`. In receive those two events leave it set.
- R9: A status-1 read arms only the flags that are 1 at that read. A second access clears a flag only when that flag is armed. Out-of-order accesses and the wrong kind of second access leave the flag set.
- R10: When a set event and a completing clear fall in the same cycle, the flag stays 1. The arm is consumed, so another status-1 read is needed before the next clear.
- R11: While `enable`=0, all flags and arms are 0 and no set takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Peripheral enable |
| stretchOff | input | 1 | 1 = clock stretching disabled |
| errChkOn | input | 1 | Error-check byte insertion enabled |
| txDir | input | 1 | 1 = transmitting, 0 = receiving |
| tenBitMode | input | 1 | Master uses 10-bit addressing |
| matchEn | input | 4 | Enables for slave match kinds 1..4 |
| evStartGen | input | 1 | Pulse: Start condition generated |
| evStopSeen | input | 1 | Pulse: Stop condition |
| evMAddr | input | 1 | Pulse: master finished an address byte |
| mAddrSecond | input | 1 | With evMAddr: second byte of a 10-bit address |
| evSlvMatch | input | 1 | Pulse: slave address recognized |
| matchKind | input | 3 | With evSlvMatch: kind of match |
| evByteDone | input | 1 | Pulse: data byte with acknowledge bit done |
| nackIn | input | 1 | With the byte events: byte was NACKed |
| rxNotEmpty | input | 1 | Receive buffer still unread |
| txEmpty | input | 1 | Transmit buffer still unwritten |
| rdStat1 | input | 1 | Strobe: status register 1 read |
| rdStat2 | input | 1 | Strobe: status register 2 read |
| rdData | input | 1 | Strobe: data register read |
| wrData | input | 1 | Strobe: data register write |
| statusLo | output | 4 | Flags: bit 0 start, 1 address, 2 byte finished, 3 header |

## Verification
A hardware set event and the completing second access of a software clear can fall in the same cycle. The bench provokes this on the start flag. It arms the flag with a status-1 read, then drives `evStartGen` together with `wrData` on one clock. It judges the result from the ports: the flag must read 1 one cycle later. A further lone `wrData` must also leave it at 1, which shows the arm was consumed. A second collision, between the peripheral-enable wipe and a set event, must leave the flag at 0.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;
  localparam int FLAG_CNT = 4;
  localparam int SB_IDX   = 0;
  localparam int ADDR_IDX = 1;
  localparam int BTF_IDX  = 2;
  localparam int HDR_IDX  = 3;
  localparam int OPT_CNT  = 4;
  localparam int KIND_W   = $clog2(OPT_CNT + 1) + ((OPT_CNT + 1) == (1 << $clog2(OPT_CNT + 1)) ? 1 : 0);

  typedef struct packed {
    logic                wipe;
    logic [FLAG_CNT-1:0] setReq;
    logic [FLAG_CNT-1:0] clrReq;
  } flagCmd_t;
endpackage

// File: rtl/i2c_flag_ctrl.sv
module i2c_flag_ctrl
  import i2c_flag_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic                stretchOff,
  input  logic                errChkOn,
  input  logic                txDir,
  input  logic                tenBitMode,
  input  logic [OPT_CNT-1:0]  matchEn,
  input  logic                evStartGen,
  input  logic                evStopSeen,
  input  logic                evMAddr,
  input  logic                mAddrSecond,
  input  logic                evSlvMatch,
  input  logic [KIND_W-1:0]   matchKind,
  input  logic                evByteDone,
  input  logic                nackIn,
  input  logic                rxNotEmpty,
  input  logic                txEmpty,
  input  logic                rdStat1,
  input  logic                rdStat2,
  input  logic                rdData,
  input  logic                wrData,
  input  logic [FLAG_CNT-1:0] flags,
  output flagCmd_t            cmd
);
  logic [FLAG_CNT-1:0] armQ;
  logic [FLAG_CNT-1:0] secondAcc;
  logic                optHit;
  logic                slvOk;
  logic                byteDue;

  always_comb begin
    optHit = 1'b0;
    for (int k = 0; k < OPT_CNT; k++) begin
      if (matchKind == KIND_W'(k + 1) && matchEn[k]) optHit = 1'b1;
    end
    slvOk   = evSlvMatch && (matchKind == '0 || optHit);
    byteDue = txDir ? (txEmpty && !errChkOn) : rxNotEmpty;

    secondAcc           = '0;
    secondAcc[SB_IDX]   = wrData;
    secondAcc[HDR_IDX]  = wrData;
    secondAcc[ADDR_IDX] = rdStat2;
    secondAcc[BTF_IDX]  = rdData || wrData;

    cmd.wipe             = !enable;
    cmd.setReq           = '0;
    cmd.setReq[SB_IDX]   = evStartGen;
    cmd.setReq[HDR_IDX]  = evMAddr && tenBitMode && !mAddrSecond && !nackIn;
    cmd.setReq[ADDR_IDX] = (evMAddr && !nackIn && (!tenBitMode || mAddrSecond)) || slvOk;
    cmd.setReq[BTF_IDX]  = evByteDone && !nackIn && !stretchOff && byteDue;

    cmd.clrReq          = armQ & secondAcc;
    cmd.clrReq[BTF_IDX] = cmd.clrReq[BTF_IDX] || (txDir && (evStartGen || evStopSeen));
  end

  for (genvar i = 0; i < FLAG_CNT; i++) begin : g_arm
    always_ff @(posedge clk) begin
      if (rst || !enable)                   armQ[i] <= 1'b0;
      else if (cmd.clrReq[i] || !flags[i])  armQ[i] <= 1'b0;
      else if (rdStat1)                     armQ[i] <= 1'b1;
    end

    // R9: an arm only appears after a status-1 read
    p_arm_after_read_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(armQ[i]) |-> $past(rdStat1));
    // R9: an armed flag is always a set flag
    p_arm_implies_flag_r9: assert property (@(posedge clk) disable iff (rst)
      armQ[i] |-> flags[i]);
  end
endmodule

// File: rtl/i2c_flag_regs.sv
module i2c_flag_regs
  import i2c_flag_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  flagCmd_t            cmd,
  input  logic                enable,
  input  logic                stretchOff,
  input  logic                nackIn,
  input  logic                txDir,
  input  logic                evStartGen,
  input  logic                evStopSeen,
  input  logic                rdStat2,
  input  logic                rdData,
  input  logic                wrData,
  output logic [FLAG_CNT-1:0] flags
);
  for (genvar i = 0; i < FLAG_CNT; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || cmd.wipe)       flags[i] <= 1'b0;
      else if (cmd.setReq[i])    flags[i] <= 1'b1;
      else if (cmd.clrReq[i])    flags[i] <= 1'b0;
    end
  end

  // R11: a low enable leaves every flag at zero
  p_enable_wipes_r11: assert property (@(posedge clk) disable iff (rst)
    !enable |=> flags == '0);
  // R2: start flag falls only through a data write
  p_sb_clear_write_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(flags[SB_IDX]) && $past(enable) |-> $past(wrData));
  // R6: address flag falls only through a status-2 read
  p_addr_clear_stat2_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(flags[ADDR_IDX]) && $past(enable) |-> $past(rdStat2));
  // R8: byte-finished flag falls on a data access or a transmit start/stop
  p_btf_clear_src_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(flags[BTF_IDX]) && $past(enable) |->
      $past(rdData || wrData || (txDir && (evStartGen || evStopSeen))));
  // R7: byte-finished never rises with stretching off or after a NACK
  p_btf_rise_ok_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[BTF_IDX]) |-> $past(!stretchOff && !nackIn));
  // R3: header flag never rises after a NACK
  p_hdr_no_nack_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[HDR_IDX]) |-> $past(!nackIn));
endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags
  import i2c_flag_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  input  logic        stretchOff,
  input  logic        errChkOn,
  input  logic        txDir,
  input  logic        tenBitMode,
  input  logic [3:0]  matchEn,
  input  logic        evStartGen,
  input  logic        evStopSeen,
  input  logic        evMAddr,
  input  logic        mAddrSecond,
  input  logic        evSlvMatch,
  input  logic [2:0]  matchKind,
  input  logic        evByteDone,
  input  logic        nackIn,
  input  logic        rxNotEmpty,
  input  logic        txEmpty,
  input  logic        rdStat1,
  input  logic        rdStat2,
  input  logic        rdData,
  input  logic        wrData,
  output logic [3:0]  statusLo
);
  flagCmd_t            cmd;
  logic [FLAG_CNT-1:0] flags;

  i2c_flag_ctrl u_ctrl (
    .clk, .rst, .enable, .stretchOff, .errChkOn, .txDir, .tenBitMode,
    .matchEn, .evStartGen, .evStopSeen, .evMAddr, .mAddrSecond,
    .evSlvMatch, .matchKind, .evByteDone, .nackIn, .rxNotEmpty, .txEmpty,
    .rdStat1, .rdStat2, .rdData, .wrData, .flags, .cmd
  );

  i2c_flag_regs u_regs (
    .clk, .rst, .cmd, .enable, .stretchOff, .nackIn, .txDir,
    .evStartGen, .evStopSeen, .rdStat2, .rdData, .wrData, .flags
  );

  assign statusLo = flags;
endmodule

// File: tb/test_i2c_status_flags.sv
module test_i2c_status_flags;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b1, stretchOff = 1'b0, errChkOn = 1'b0, txDir = 1'b0, tenBitMode = 1'b0;
  logic [3:0] matchEn = '0;
  logic evStartGen = 1'b0, evStopSeen = 1'b0, evMAddr = 1'b0, mAddrSecond = 1'b0;
  logic evSlvMatch = 1'b0;
  logic [2:0] matchKind = '0;
  logic evByteDone = 1'b0, nackIn = 1'b0, rxNotEmpty = 1'b0, txEmpty = 1'b0;
  logic rdStat1 = 1'b0, rdStat2 = 1'b0, rdData = 1'b0, wrData = 1'b0;
  logic [3:0] statusLo;
  int checks = 0;
  int errs = 0;

  always #5 clk = ~clk;

  i2c_status_flags i_i2c_status_flags (.*);

  task automatic chk(input string req, input logic [3:0] exp);
    checks++;
    if (statusLo !== exp) begin
      errs++;
      $display("FAIL %s actual %b expected %b", req, statusLo, exp);
    end
  endtask

  task automatic stat1();   rdStat1 = 1; @(negedge clk); rdStat1 = 0; endtask
  task automatic stat2();   rdStat2 = 1; @(negedge clk); rdStat2 = 0; endtask
  task automatic rdD();     rdData = 1;  @(negedge clk); rdData = 0;  endtask
  task automatic wrD();     wrData = 1;  @(negedge clk); wrData = 0;  endtask
  task automatic startG();  evStartGen = 1; @(negedge clk); evStartGen = 0; endtask
  task automatic stopS();   evStopSeen = 1; @(negedge clk); evStopSeen = 0; endtask
  task automatic mAddr(input logic sec, input logic nk);
    evMAddr = 1; mAddrSecond = sec; nackIn = nk;
    @(negedge clk); evMAddr = 0; mAddrSecond = 0; nackIn = 0;
  endtask
  task automatic slvHit(input logic [2:0] k);
    evSlvMatch = 1; matchKind = k; @(negedge clk); evSlvMatch = 0; matchKind = 0;
  endtask
  task automatic byteD(input logic nk);
    evByteDone = 1; nackIn = nk; @(negedge clk); evByteDone = 0; nackIn = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset", 4'b0000);
  endtask

  task automatic t_start();
    startG();          chk("R2 start set", 4'b0001);
    wrD();             chk("R9 write without status-1 read", 4'b0001);
    stat1(); stat2();  chk("R9 wrong second access", 4'b0001);
    wrD();             chk("R2 start clear", 4'b0000);
  endtask

  task automatic t_header();
    tenBitMode = 1;
    mAddr(0, 1);       chk("R3 header NACK", 4'b0000);
    mAddr(0, 0);       chk("R3 header set / R4 no addr on first", 4'b1000);
    mAddr(1, 1);       chk("R4 second byte NACK", 4'b1000);
    mAddr(1, 0);       chk("R4 10-bit second byte", 4'b1010);
    stat1(); wrD();    chk("R3 header clear keeps addr", 4'b0010);
    stat2();           chk("R6 addr clear after shared read", 4'b0000);
    tenBitMode = 0;
  endtask

  task automatic t_addr7();
    mAddr(0, 1);       chk("R4 7-bit NACK", 4'b0000);
    mAddr(0, 0);       chk("R4 7-bit set", 4'b0010);
    stat2();           chk("R9 status-2 alone", 4'b0010);
    stat1(); wrD();    chk("R9 write pairs not with addr", 4'b0010);
    stat2();           chk("R6 addr clear", 4'b0000);
  endtask

  task automatic t_slave();
    matchEn = 4'b0000;
    slvHit(3'd0);      chk("R5 own address", 4'b0010);
    stat1(); stat2();  chk("R6 clear slave addr", 4'b0000);
    for (int k = 1; k <= 4; k++) begin
      slvHit(3'(k));   chk($sformatf("R5 kind %0d disabled", k), 4'b0000);
      matchEn = 4'(1 << (k - 1));
      slvHit(3'(k));   chk($sformatf("R5 kind %0d enabled", k), 4'b0010);
      stat1(); stat2();
      matchEn = 4'b0000;
    end
    matchEn = 4'b1111;
    slvHit(3'd5);      chk("R5 kind 5 never", 4'b0000);
    matchEn = 4'b0000;
  endtask

  task automatic t_btf();
    txDir = 0; rxNotEmpty = 1;
    byteD(0);          chk("R7 rx set", 4'b0100);
    stopS();           chk("R8 rx stop keeps", 4'b0100);
    stat1(); rdD();    chk("R8 clear by data read", 4'b0000);
    byteD(1);          chk("R7 rx NACK", 4'b0000);
    stretchOff = 1;
    byteD(0);          chk("R7 stretching off", 4'b0000);
    stretchOff = 0; rxNotEmpty = 0;
    byteD(0);          chk("R7 rx buffer read", 4'b0000);
    txDir = 1; txEmpty = 1;
    byteD(0);          chk("R7 tx set", 4'b0100);
    stat1(); wrD();    chk("R8 clear by data write", 4'b0000);
    errChkOn = 1;
    byteD(0);          chk("R7 error-check byte next", 4'b0000);
    errChkOn = 0;
    byteD(0); stopS(); chk("R8 tx stop clears", 4'b0000);
    byteD(0); startG(); chk("R8 tx start clears", 4'b0001);
    stat1(); wrD();
    txEmpty = 0;
    byteD(0);          chk("R7 tx buffer full", 4'b0000);
    txDir = 0;
  endtask

  task automatic t_collide();
    startG(); stat1();
    evStartGen = 1; wrData = 1; @(negedge clk); evStartGen = 0; wrData = 0;
    chk("R10 set wins", 4'b0001);
    wrD();             chk("R10 arm consumed", 4'b0001);
    stat1(); wrD();    chk("R10 fresh sequence clears", 4'b0000);
  endtask

  task automatic t_enable();
    startG(); mAddr(0, 0); stat1();
    enable = 0; @(negedge clk);
    chk("R11 enable low wipes", 4'b0000);
    evStartGen = 1; @(negedge clk); evStartGen = 0;
    chk("R11 set blocked", 4'b0000);
    enable = 1;
    startG();          chk("R11 set after re-enable", 4'b0001);
    wrD();             chk("R11 arm wiped", 4'b0001);
    stat1(); wrD();    chk("R2 clear after re-enable", 4'b0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_start();
    t_header();
    t_addr7();
    t_slave();
    t_btf();
    t_collide();
    t_enable();
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule